// File: doc/BRIEF.md
# Per-Backend Visible-Fragment Snapshot Writer

This block keeps one running tally of depth-passing fragments for each of several depth backends (four by default). Each backend raises a one-cycle pass strobe per visible fragment, and its tally grows by one for every strobe. The tally is never cleared by a snapshot. A visibility query takes two snapshots, one when the query opens and one when it closes. Software then subtracts the opening value from the closing value for each backend and adds the differences.

A dump event strobe captures all tallies in the same cycle, together with a buffer base address and a phase select (0 = opening snapshot, 1 = closing snapshot). The captured snapshot goes into a small pending queue. A write engine turns each snapshot into one 64-bit word per backend, in backend order. Every word has its top bit set as a valid flag and the tally zero-extended in the bits below it. The words are interleaved so that the opening and closing words of one backend sit next to each other: word index 2*i holds the opening value and 2*i+1 holds the closing value. The whole result area is 64 bytes.

The memory side is a valid/ready write port. Once valid is high, address and data stay fixed and valid stays high until ready is seen. Ready may stall for any number of cycles, and stalling loses nothing. The dump strobe, base, select and the done pulse are plain control pins. The issuer must not have more than PEND_DEPTH snapshots outstanding at once.

Top module: `fragcnt_dumper`

## Requirements
- R1: After synchronous reset `wr_valid_o` and `done_o` are 0 and every tally is 0, so the first snapshot writes words equal to 64'h8000_0000_0000_0000.
- R2: Every written word has bit 63 set to 1 and bits 62:0 equal to the backend's tally, zero-extended from CNT_W bits.
- R3: With select 0 the word for backend i is written at byte address base + 16*i.
- R4: With select 1 the word for backend i is written at byte address base + 8 + 16*i.
- R5: The words of one snapshot are written in backend order 0, 1, 2, 3.
- R6: A snapshot holds the tallies as registered at the dump-strobe edge. A pass strobe in the same cycle as the dump strobe, or in any later cycle, counts only toward later snapshots.
- R7: While `wr_valid_o` is 1 and `wr_ready_i` is 0, the next cycle keeps `wr_valid_o` at 1 with `wr_addr_o` and `wr_data_o` unchanged.
- R8: Dump strobes that arrive while earlier snapshots are still being written are queued (up to PEND_DEPTH outstanding) and written in arrival order, with none dropped.
- R9: A tally saturates at 2^CNT_W-1 and never wraps.
- R10: `done_o` is a one-cycle pulse in the cycle after the last word of a snapshot is accepted.
- R11: Taking a snapshot does not clear or change the tallies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pass_i | input | NUM_BE | Per-backend visible-fragment strobe |
| dump_i | input | 1 | Snapshot request strobe |
| base_i | input | ADDR_W | Result buffer base byte address |
| end_sel_i | input | 1 | 0 = opening snapshot, 1 = closing snapshot |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory accepts write |
| wr_addr_o | output | ADDR_W | Write byte address |
| wr_data_o | output | 64 | Valid flag plus tally |
| done_o | output | 1 | Snapshot fully written pulse |

## Verification
The bench builds the block with CNT_W = 6, so a continuous burst of 80 strobes drives every tally into saturation at 63. ADDR_W = 16 keeps the addresses readable. NUM_BE = 4 and PEND_DEPTH = 2 are kept, so two snapshots can be queued back to back while pseudo-random ready stalls hold the first one. This exercises queue ordering, the hold rule on stalls and counting during a write sequence together.

// File: rtl/fragcnt_pkg.sv
package fragcnt_pkg;
  localparam int WORD_W    = 64;
  localparam int VALID_BIT = 63;
  localparam int PAY_W     = 63;
  localparam int QW_SHIFT  = 3;   // bytes per word = 8
  typedef logic [WORD_W-1:0] qword_t;
endpackage

// File: rtl/fragcnt_counter.sv
module fragcnt_counter #(
  parameter int CNT_W = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pass_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_o <= '0;
    else if (pass_i && cnt_o != CMAX) cnt_o <= cnt_o + 1'b1;
  end

  // R9: once at the ceiling, stays there
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    cnt_o == CMAX |=> cnt_o == CMAX);
  // R11: tally never decreases outside reset
  a_r11_monotonic: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/fragcnt_pending.sv
module fragcnt_pending #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW:0]      wp, rp;
  logic             full;

  assign empty_o = (wp == rp);
  assign full    = (wp[PW-1:0] == rp[PW-1:0]) && (wp[PW] != rp[PW]);
  assign head_o  = mem[rp[PW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_i) begin
        mem[wp[PW-1:0]] <= din_i;
        wp <= wp + 1'b1;
      end
      if (pop_i && !empty_o) rp <= rp + 1'b1;
    end
  end

  // R8: a snapshot must never arrive with no free slot
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full);
endmodule

// File: rtl/fragcnt_writer.sv
module fragcnt_writer
  import fragcnt_pkg::*;
#(
  parameter int NUM_BE = 4,
  parameter int CNT_W  = 63,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    empty_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic                    sel_i,
  input  logic [NUM_BE*CNT_W-1:0] cnts_i,
  output logic                    pop_o,
  output logic                    wr_valid_o,
  input  logic                    wr_ready_i,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output qword_t                  wr_data_o,
  output logic                    done_o
);
  localparam int IW = (NUM_BE > 1) ? $clog2(NUM_BE) : 1;
  localparam logic [IW-1:0] LAST = IW'(NUM_BE - 1);

  logic [IW-1:0]    idx;
  logic             hs, last;
  logic [CNT_W-1:0] cur;

  assign wr_valid_o = !empty_i;
  assign hs         = wr_valid_o && wr_ready_i;
  assign last       = (idx == LAST);
  assign pop_o      = hs && last;
  assign cur        = cnts_i[idx*CNT_W +: CNT_W];
  // offset = idx*16 + sel*8
  assign wr_addr_o  = base_i + ADDR_W'({idx, sel_i, 3'b000});
  assign wr_data_o  = {1'b1, PAY_W'(cur)};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= pop_o;
      if (hs) idx <= last ? '0 : idx + 1'b1;
    end
  end

  // R7: a stalled request holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  // R2: valid flag present on every word
  a_r2_valid_bit: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> wr_data_o[VALID_BIT]);
  // R10: done follows acceptance of a final word
  a_r10_done: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && done_o |-> $past(wr_valid_o && wr_ready_i));
endmodule

// File: rtl/fragcnt_dumper.sv
module fragcnt_dumper
  import fragcnt_pkg::*;
#(
  parameter int NUM_BE     = 4,
  parameter int CNT_W      = 63,
  parameter int ADDR_W     = 32,
  parameter int PEND_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_BE-1:0] pass_i,
  input  logic              dump_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              end_sel_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [63:0]       wr_data_o,
  output logic              done_o
);
  localparam int SNAP_W = NUM_BE * CNT_W;
  localparam int ENT_W  = ADDR_W + 1 + SNAP_W;

  logic [SNAP_W-1:0] cnt_flat;
  logic [ENT_W-1:0]  head;
  logic              empty, pop;

  for (genvar g = 0; g < NUM_BE; g++) begin : g_be
    fragcnt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .pass_i (pass_i[g]),
      .cnt_o  (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  fragcnt_pending #(.WIDTH(ENT_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .push_i  (dump_i),
    .din_i   ({base_i, end_sel_i, cnt_flat}),
    .pop_i   (pop),
    .head_o  (head),
    .empty_o (empty)
  );

  fragcnt_writer #(.NUM_BE(NUM_BE), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .empty_i    (empty),
    .base_i     (head[ENT_W-1 -: ADDR_W]),
    .sel_i      (head[SNAP_W]),
    .cnts_i     (head[SNAP_W-1:0]),
    .pop_o      (pop),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o)
  );
endmodule

// File: tb/fragcnt_dumper_bench.sv
module fragcnt_dumper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int CW = 6;
  localparam int AW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 0;
  logic          rst = 1;
  logic [NB-1:0] pass_i = '0;
  logic          dump_i = 0;
  logic [AW-1:0] base_i = 16'h1040;
  logic          end_sel_i = 0;
  logic          wr_valid_o, wr_ready_i, done_o;
  logic [AW-1:0] wr_addr_o;
  logic [63:0]   wr_data_o;

  int checks = 0, errors = 0;
  int mc[NB];
  int unsigned qa[$];
  logic [63:0] qd[$];
  bit ql[$];
  string qt[$];
  bit done_exp = 0;
  bit prev_stall = 0;
  bit rmode = 0;
  logic [7:0] lf = 8'h5a;

  always #(CLK_PERIOD/2) clk = ~clk;

  fragcnt_dumper #(.NUM_BE(NB), .CNT_W(CW), .ADDR_W(AW), .PEND_DEPTH(2)) u_fragcnt_dumper (
    .clk(clk), .rst(rst), .pass_i(pass_i), .dump_i(dump_i), .base_i(base_i),
    .end_sel_i(end_sel_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [NB-1:0] p, input bit d, input bit s, input string tag);
    bit hs, lst;
    @(negedge clk);
    pass_i = p; dump_i = d; end_sel_i = s;
    wr_ready_i = rmode ? (lf[0] | lf[3]) : 1'b1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    #1;
    chk(prev_stall ? "R7 valid" : "R8 valid", 64'(wr_valid_o), 64'(qa.size() != 0));
    if (wr_valid_o && qa.size() != 0) begin
      chk({qt[0], " addr"}, 64'(wr_addr_o), 64'(qa[0]));
      chk({qt[0], " data"}, wr_data_o, qd[0]);
    end
    chk("R10 done", 64'(done_o), 64'(done_exp));
    hs = wr_valid_o && wr_ready_i && qa.size() != 0;
    prev_stall = wr_valid_o && !wr_ready_i;
    done_exp = 0;
    if (hs) begin
      lst = ql[0];
      void'(qa.pop_front()); void'(qd.pop_front());
      void'(ql.pop_front()); void'(qt.pop_front());
      done_exp = lst;
    end
    if (d) begin
      for (int i = 0; i < NB; i++) begin
        qa.push_back(int'(base_i) + 16*i + (s ? 8 : 0));
        qd.push_back(64'h8000_0000_0000_0000 | 64'(mc[i]));
        ql.push_back(i == NB-1);
        qt.push_back(tag);
      end
    end
    for (int i = 0; i < NB; i++)
      if (p[i] && mc[i] < CMAX) mc[i]++;
  endtask

  task automatic dump(input logic [NB-1:0] p, input bit s, input string tag);
    while (qa.size() > NB) step(p, 0, 0, "");
    step(p, 1, s, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, 0, 0, "");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) mc[i] = 0;
    wr_ready_i = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 valid after reset", 64'(wr_valid_o), 64'd0);
    chk("R1 done after reset", 64'(done_o), 64'd0);
    // R1: zero tallies
    dump('0, 0, "R1");
    idle(6);
    // R3 opening snapshot after varied strobes
    for (int c = 0; c < 20; c++) step({c[0], c % 3 == 0, 1'b1, 1'b0}, 0, 0, "");
    dump('0, 0, "R3");
    idle(6);
    // R4 closing snapshot; R6 strobes in dump cycle excluded
    for (int c = 0; c < 7; c++) step({1'b0, c[1], 1'b1, c[0]}, 0, 0, "");
    dump(4'hF, 1, "R4");
    dump(4'hF, 1, "R6");
    idle(10);
    // R8/R11 with stalls, strobes during writes
    rmode = 1;
    base_i = 16'h2200;
    dump(4'b0101, 0, "R8");
    dump(4'b1010, 1, "R11");
    for (int c = 0; c < 30; c++) step(4'(c), 0, 0, "");
    dump(4'b0011, 0, "R5");
    idle(30);
    // R9 saturation
    for (int c = 0; c < 80; c++) step(4'hF, 0, 0, "");
    dump(4'hF, 1, "R9");
    dump('0, 0, "R2");
    idle(40);
    rmode = 0;
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule